// File: doc/BRIEF.md
# Single-Cycle Add/Subtract Register Datapath

This block is the smallest useful processor datapath: every clock cycle it fetches one 32-bit instruction, reads two operands from a 32-entry register file, adds or subtracts them, and writes the result back. It has no other instructions. A program counter indexes a small instruction store. An adder beside the counter produces the next address. A fixed field split pulls three register indices out of the word, and a single arithmetic unit produces the result that is written back.

The instruction store is filled through a write port. Loading is normally done while the datapath is held in reset. Once reset is released, the datapath runs freely and retires one instruction per cycle. A debug port gives registered read access to any register. Because the instruction set has no way to create a nonzero value, the port can also write a register, which is how test operands are seeded. A debug write shares the register file's single write port and overrides the instruction's writeback in the same cycle.

Top module: `addsub_datapath`

## Requirements
- R1: While reset is high at a rising edge, the PC becomes 0, every register becomes 0 and the debug read data becomes 0. Debug writes are ignored during reset.
- R2: In every cycle out of reset the PC increases by exactly 4. The instruction executed is the stored word at index PC[IADDR_W+1:2].
- R3: The destination index is instruction bits [11:7], the first source index is bits [19:15] and the second source index is bits [24:20]. The result is written to the destination at the rising edge that ends the instruction's cycle, and any index 1 to 31 is usable.
- R4: When instruction bit 30 is 0, the result is source1 + source2 modulo 2^32.
- R5: When instruction bit 30 is 1, the result is source1 - source2 modulo 2^32.
- R6: Opcode bits [6:0], bits [14:12] and instruction bits 31 and [29:25] do not affect execution.
- R7: Register 0 always reads as 0. Instruction writes and debug writes to it are ignored.
- R8: An instruction sees the result of the previous instruction. An instruction whose destination is also a source reads the old value.
- R9: With debug write enable high, the debug data is written to the register at the debug index at the next edge, overriding that cycle's instruction writeback. The debug read data shows the register at the debug index one cycle after the index is presented.
- R10: A word presented on the instruction-store write port with its enable high is stored at the given index at the rising edge, including while reset is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_we | input | 1 | Instruction-store write enable |
| imem_waddr | input | 6 | Instruction-store word index |
| imem_wdata | input | 32 | Instruction word to store |
| dbg_we | input | 1 | Debug register write enable |
| dbg_addr | input | 5 | Debug register index for read and write |
| dbg_wdata | input | 32 | Debug register write data |
| dbg_rdata | output | 32 | Registered debug read data |
| pc_o | output | 32 | Current program counter |

## Verification
The assertions assume that reset is held high for at least one edge before the datapath runs. They also assume that no input carries unknown values once reset is released. The debug-write check additionally assumes that reset stays low on the edge that follows the write. The bench loads the instruction store only while reset is high. It fills every unused slot with the all-zero word, which writes register 0 and so has no effect. It issues debug writes only in cycles whose instruction is such a no-op, apart from the one deliberate collision that exercises the override.

// File: rtl/addsub_pkg.sv
`timescale 1ns/1ps
package addsub_pkg;
  localparam int INSTR_W   = 32;
  localparam int REG_IDX_W = 5;

  typedef struct packed {
    logic [REG_IDX_W-1:0] dst;
    logic [REG_IDX_W-1:0] src_a;
    logic [REG_IDX_W-1:0] src_b;
    logic                 negate;
  } rr_fields_t;

  function automatic rr_fields_t split_fields(input logic [INSTR_W-1:0] word);
    rr_fields_t f;
    f.dst    = word[11:7];
    f.src_a  = word[19:15];
    f.src_b  = word[24:20];
    f.negate = word[30];
    return f;
  endfunction
endpackage

// File: rtl/as_pc_unit.sv
`timescale 1ns/1ps
module as_pc_unit #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  output logic [XLEN-1:0] pc_q
);
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  logic [XLEN-1:0] pc_next;

  assign pc_next = pc_q + STEP;

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_next;
  end

  logic ran_q;
  always_ff @(posedge clk) begin
    if (rst) ran_q <= 1'b0;
    else     ran_q <= 1'b1;
  end

  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    ran_q |-> pc_q == $past(pc_q) + STEP) else $error("pc step"); // R2
  AST_PC_RESET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> pc_q == '0) else $error("pc reset"); // R1
endmodule

// File: rtl/as_imem.sv
`timescale 1ns/1ps
module as_imem #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_idx,
  input  logic [WIDTH-1:0] wr_word,
  input  logic [AW-1:0]    rd_idx,
  output logic [WIDTH-1:0] rd_word
);
  logic [WIDTH-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_idx] <= wr_word;
  end

  assign rd_word = store[rd_idx];
endmodule

// File: rtl/as_regfile.sv
`timescale 1ns/1ps
module as_regfile #(
  parameter int XLEN  = 32,
  parameter int NREGS = 32,
  localparam int IW   = $clog2(NREGS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [IW-1:0]   ra1,
  input  logic [IW-1:0]   ra2,
  output logic [XLEN-1:0] rd1,
  output logic [XLEN-1:0] rd2,
  input  logic            wb_we,
  input  logic [IW-1:0]   wb_addr,
  input  logic [XLEN-1:0] wb_data,
  input  logic            dbg_we,
  input  logic [IW-1:0]   dbg_addr,
  input  logic [XLEN-1:0] dbg_wdata,
  output logic [XLEN-1:0] dbg_rdata
);
  logic [XLEN-1:0] regs [NREGS];
  logic            w_en;
  logic [IW-1:0]   w_addr;
  logic [XLEN-1:0] w_data;

  always_comb begin
    w_en   = dbg_we | wb_we;
    w_addr = dbg_we ? dbg_addr  : wb_addr;
    w_data = dbg_we ? dbg_wdata : wb_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (w_en && (w_addr != '0)) begin
      regs[w_addr] <= w_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) dbg_rdata <= '0;
    else     dbg_rdata <= regs[dbg_addr];
  end

  assign rd1 = regs[ra1];
  assign rd2 = regs[ra2];

  AST_ZERO_REG: assert property (@(posedge clk) disable iff (rst)
    (ra1 == '0) |-> (rd1 == '0)) else $error("x0 nonzero"); // R7
  AST_WB_LANDS: assert property (@(posedge clk) disable iff (rst)
    (wb_we && !dbg_we && wb_addr != '0) |=> regs[$past(wb_addr)] == $past(wb_data))
    else $error("writeback lost"); // R3
  AST_DBG_WINS: assert property (@(posedge clk) disable iff (rst)
    (dbg_we && dbg_addr != '0) |=> regs[$past(dbg_addr)] == $past(dbg_wdata))
    else $error("debug write lost"); // R9
endmodule

// File: rtl/as_alu.sv
`timescale 1ns/1ps
module as_alu #(
  parameter int XLEN = 32
) (
  input  logic            negate,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  output logic [XLEN-1:0] res
);
  logic [XLEN-1:0] opb_eff;

  assign opb_eff = negate ? ~opb : opb;
  assign res     = opa + opb_eff + XLEN'(negate);

  always_comb begin
    if (!$isunknown({negate, opa, opb})) begin
      AST_ALU_INVERSE: assert (negate ? (res + opb) == opa : (res - opb) == opa)
        else $error("alu result"); // R4, R5
    end
  end
endmodule

// File: rtl/addsub_datapath.sv
`timescale 1ns/1ps
module addsub_datapath
  import addsub_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int NREGS      = 32,
  parameter int IMEM_DEPTH = 64,
  localparam int IADDR_W   = $clog2(IMEM_DEPTH),
  localparam int RIDX_W    = $clog2(NREGS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               imem_we,
  input  logic [IADDR_W-1:0] imem_waddr,
  input  logic [31:0]        imem_wdata,
  input  logic               dbg_we,
  input  logic [RIDX_W-1:0]  dbg_addr,
  input  logic [XLEN-1:0]    dbg_wdata,
  output logic [XLEN-1:0]    dbg_rdata,
  output logic [XLEN-1:0]    pc_o
);
  logic [XLEN-1:0]    pc_q;
  logic [INSTR_W-1:0] instr;
  rr_fields_t         fld;
  logic [XLEN-1:0]    src_a_val;
  logic [XLEN-1:0]    src_b_val;
  logic [XLEN-1:0]    result;
  logic               unused_bits;

  as_pc_unit #(.XLEN(XLEN)) u_pc (
    .clk  (clk),
    .rst  (rst),
    .pc_q (pc_q)
  );

  as_imem #(.WIDTH(INSTR_W), .DEPTH(IMEM_DEPTH)) u_imem (
    .clk     (clk),
    .wr_en   (imem_we),
    .wr_idx  (imem_waddr),
    .wr_word (imem_wdata),
    .rd_idx  (pc_q[IADDR_W+1:2]),
    .rd_word (instr)
  );

  assign fld = split_fields(instr);
  assign unused_bits = ^{instr[31], instr[29:25], instr[14:12], instr[6:0],
                         pc_q[1:0], pc_q[XLEN-1:IADDR_W+2]};

  as_regfile #(.XLEN(XLEN), .NREGS(NREGS)) u_rf (
    .clk       (clk),
    .rst       (rst),
    .ra1       (RIDX_W'(fld.src_a)),
    .ra2       (RIDX_W'(fld.src_b)),
    .rd1       (src_a_val),
    .rd2       (src_b_val),
    .wb_we     (1'b1),
    .wb_addr   (RIDX_W'(fld.dst)),
    .wb_data   (result),
    .dbg_we    (dbg_we),
    .dbg_addr  (dbg_addr),
    .dbg_wdata (dbg_wdata),
    .dbg_rdata (dbg_rdata)
  );

  as_alu #(.XLEN(XLEN)) u_alu (
    .negate (fld.negate),
    .opa    (src_a_val),
    .opb    (src_b_val),
    .res    (result)
  );

  assign pc_o = pc_q;
endmodule

// File: tb/addsub_datapath_tb.sv
`timescale 1ns/1ps
module addsub_datapath_tb;
  localparam int DEPTH = 64;
  localparam int NSEED = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        imem_we = 1'b0;
  logic [5:0]  imem_waddr = '0;
  logic [31:0] imem_wdata = '0;
  logic        dbg_we = 1'b0;
  logic [4:0]  dbg_addr = '0;
  logic [31:0] dbg_wdata = '0;
  logic [31:0] dbg_rdata;
  logic [31:0] pc_o;

  int checks = 0;
  int errors = 0;

  logic [31:0] prog [16];
  int          plen;
  logic        seed_en [NSEED];
  logic [4:0]  seed_a  [NSEED];
  logic [31:0] seed_v  [NSEED];
  logic        late_en;
  logic [4:0]  late_a;
  logic [31:0] late_v;

  addsub_datapath u_dut (
    .clk(clk), .rst(rst), .imem_we(imem_we), .imem_waddr(imem_waddr),
    .imem_wdata(imem_wdata), .dbg_we(dbg_we), .dbg_addr(dbg_addr),
    .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata), .pc_o(pc_o)
  );

  always #4 clk = ~clk;

  function automatic logic [31:0] rr(input logic neg, input int rd, input int rs1, input int rs2);
    return {1'b0, neg, 5'b0, 5'(rs2), 5'(rs1), 3'b000, 5'(rd), 7'b0110011};
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic read_reg(input int idx, output logic [31:0] val);
    dbg_addr = 5'(idx);
    step();
    val = dbg_rdata;
  endtask

  task automatic clear_setup();
    plen = 0;
    late_en = 1'b0;
    for (int s = 0; s < NSEED; s++) seed_en[s] = 1'b0;
  endtask

  // R10: load under reset, program starts at word NSEED after seed slots
  task automatic run_program();
    rst = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      imem_we    = 1'b1;
      imem_waddr = 6'(i);
      imem_wdata = (i >= NSEED && i - NSEED < plen) ? prog[i-NSEED] : 32'h0;
      step();
    end
    imem_we = 1'b0;
    rst = 1'b0;
    for (int s = 0; s < NSEED; s++) begin
      dbg_we = seed_en[s]; dbg_addr = seed_a[s]; dbg_wdata = seed_v[s];
      step();
    end
    dbg_we = 1'b0;
    for (int p = 0; p < plen; p++) begin
      if (p == 0 && late_en) begin
        dbg_we = 1'b1; dbg_addr = late_a; dbg_wdata = late_v;
      end
      step();
      dbg_we = 1'b0;
    end
  endtask

  task automatic test_add_sub();
    logic [31:0] v;
    clear_setup();
    seed_en[0] = 1; seed_a[0] = 1; seed_v[0] = 32'd100;
    seed_en[1] = 1; seed_a[1] = 2; seed_v[1] = 32'd23;
    prog[0] = rr(0, 3, 1, 2);
    prog[1] = rr(1, 4, 1, 2);
    prog[2] = rr(1, 5, 2, 1);
    prog[3] = rr(0, 6, 3, 4);
    plen = 4;
    run_program();
    check("R2 pc after 8 cycles", pc_o, 32'd32);
    read_reg(3, v); check("R4 add x3", v, 32'd123);
    read_reg(4, v); check("R5 sub x4", v, 32'd77);
    read_reg(5, v); check("R5 negative sub x5", v, 32'hFFFF_FFB3);
    read_reg(6, v); check("R8 dependent add x6", v, 32'd200);
  endtask

  task automatic test_wrap_zero();
    logic [31:0] v;
    clear_setup();
    seed_en[0] = 1; seed_a[0] = 1; seed_v[0] = 32'hFFFF_FFFF;
    seed_en[1] = 1; seed_a[1] = 2; seed_v[1] = 32'd1;
    seed_en[2] = 1; seed_a[2] = 0; seed_v[2] = 32'h55;
    prog[0] = rr(0, 3, 1, 2);
    prog[1] = rr(1, 4, 0, 2);
    prog[2] = rr(0, 0, 1, 1);
    prog[3] = rr(1, 5, 1, 0);
    plen = 4;
    run_program();
    read_reg(3, v); check("R4 add wraps x3", v, 32'h0);
    read_reg(4, v); check("R5 sub wraps x4", v, 32'hFFFF_FFFF);
    read_reg(0, v); check("R7 x0 stays zero", v, 32'h0);
    read_reg(5, v); check("R7 x0 reads zero as source", v, 32'hFFFF_FFFF);
  endtask

  task automatic test_fields();
    logic [31:0] v;
    clear_setup();
    seed_en[0] = 1; seed_a[0] = 10; seed_v[0] = 32'h1000;
    seed_en[1] = 1; seed_a[1] = 20; seed_v[1] = 32'h0234;
    seed_en[2] = 1; seed_a[2] = 31; seed_v[2] = 32'd7;
    prog[0] = rr(0, 12, 10, 20) | 32'hBE00_707F;
    prog[1] = (rr(1, 13, 10, 20) & ~32'h7F) | 32'h5000;
    prog[2] = rr(0, 31, 31, 31);
    prog[3] = rr(0, 31, 31, 31);
    prog[4] = rr(0, 31, 31, 31);
    plen = 5;
    run_program();
    read_reg(12, v); check("R6 junk bits still add", v, 32'h1234);
    read_reg(13, v); check("R6 bit30 alone picks sub", v, 32'h0DCC);
    read_reg(31, v); check("R8 R3 self-update x31", v, 32'd56);
  endtask

  task automatic test_dbg_priority();
    logic [31:0] v;
    clear_setup();
    seed_en[0] = 1; seed_a[0] = 1; seed_v[0] = 32'd5;
    seed_en[1] = 1; seed_a[1] = 2; seed_v[1] = 32'd6;
    prog[0] = rr(0, 8, 1, 2);
    prog[1] = rr(0, 9, 8, 0);
    plen = 2;
    late_en = 1; late_a = 8; late_v = 32'hABCD;
    run_program();
    read_reg(8, v); check("R9 debug write overrides", v, 32'hABCD);
    read_reg(9, v); check("R9 overridden value used", v, 32'hABCD);
    read_reg(1, v); check("R9 debug read seed", v, 32'd5);
  endtask

  task automatic test_reset();
    logic [31:0] v;
    clear_setup();
    rst = 1'b1;
    dbg_addr = 5'd31;
    step();
    step();
    check("R1 pc in reset", pc_o, 32'h0);
    check("R1 debug data in reset", dbg_rdata, 32'h0);
    run_program();
    read_reg(31, v); check("R1 x31 cleared", v, 32'h0);
    read_reg(12, v); check("R1 x12 cleared", v, 32'h0);
    check("R2 pc keeps stepping", pc_o, 32'd24);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step();
    test_add_sub();
    test_wrap_zero();
    test_fields();
    test_dbg_priority();
    test_reset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule